// File: doc/BRIEF.md
# Majority-Gate Parity Tree

This block computes the parity (the XOR of all bits) of an N-bit input word, where N is a parameter. It is built only from a 3-input majority primitive and inverters, which models a logic technology whose native gate is a majority vote. A design that targets such a fabric can instantiate this block wherever it needs parity, and can read its cost figures as constant outputs.

The inputs are split into groups of three, left to right from bit 0. Each group feeds a three-gate XOR cell, and the cell outputs form the next, narrower level. This repeats as a ternary tree until one bit remains.

- A group of three uses the full cell, which has no constant gate inputs.
- A leftover group of two uses the same cell with its third input tied low.
- A leftover single bit passes straight to the next level with no gate.

The block is purely combinational. Its cost grows linearly with N and its delay grows with the base-3 logarithm of N. Three constant output ports report:

- the number of majority gates instantiated;
- the number of inverters instantiated;
- the worst-case depth in majority-gate levels.

Top module: `maj_parity_tree`

## Requirements
- R1: `parity` equals the XOR of all N bits of `in_bits` for every input pattern, and is 0 when all inputs are 0.
- R2: A full cell is made of exactly three majority gates and no constant inputs. Its output is the parity of its three inputs. It uses two inverters, one on the first-level vote and one on the third input.
- R3: When a level has two bits left over, they go to a cell whose third input is tied to 0. That cell produces the XOR of the two bits with three majority gates and one inverter.
- R4: When a level has one bit left over, that bit passes unchanged to the next level, and adds no gate and no depth.
- R5: `maj_gates` reports three times the number of cells. Expected values: N=1 gives 0, N=2 gives 3, N=3 gives 3, N=4 gives 6, N=9 gives 12, N=10 gives 15, N=40 gives 63.
- R6: `inv_gates` reports two per full cell plus one per two-input cell. Expected values: N=1 gives 0, N=2 gives 1, N=3 gives 2, N=4 gives 3, N=9 gives 8, N=10 gives 9, N=40 gives 39.
- R7: `gate_levels` reports 2 times ceil(log3 N) for N > 1, and 0 for N=1. Expected values: N=2, 3 give 2; N=4, 9 give 4; N=10 gives 6; N=40 gives 8.
- R8: With N=1 the output follows the single input directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_bits | input | N | Word whose parity is computed |
| parity | output | 1 | XOR of all bits of `in_bits` |
| maj_gates | output | CW | Constant: number of majority gates instantiated |
| inv_gates | output | CW | Constant: number of inverters instantiated |
| gate_levels | output | CW | Constant: worst-case depth in majority-gate levels |

## Verification
Assertions run on every input change and check three things:
- each majority gate against a vote count of its inputs;
- each cell's output against the parity of its inputs, including that a two-input cell's third input is held low;
- the tree output against the reduction XOR of the word.

The gate counts and depth are constants, so only the bench can confirm them, by comparing them with hand-derived figures for several widths. The bench also sweeps every input pattern for widths up to ten, including the leftover single-bit and two-bit groupings. It drives a wide instance with random sparse and dense words and with directed corner words.

// File: rtl/maj3_gate.sv
module maj3_gate (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic y
);
  assign y = (a & b) | (a & c) | (b & c);

  always_comb begin
    if (!$isunknown({a, b, c}))
      p_vote_r2: assert (y == ($countones({a, b, c}) >= 2));
  end
endmodule

// File: rtl/maj_xor_cell.sv
module maj_xor_cell #(
  parameter bit TWO_IN = 1'b0
) (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p
);
  logic vote_lo, vote_hi, vote_lo_n;

  assign vote_lo_n = ~vote_lo;

  generate
    if (TWO_IN) begin : g_two
      maj3_gate u_lo  (.a(a), .b(b), .c(c),    .y(vote_lo));
      maj3_gate u_hi  (.a(a), .b(b), .c(1'b1), .y(vote_hi));
      maj3_gate u_out (.a(vote_lo_n), .b(c), .c(vote_hi), .y(p));

      always_comb begin
        if (!$isunknown({a, b, c})) begin
          p_tied_low_r3: assert (c == 1'b0);
          p_xor2_r3: assert (p == (a ^ b));
        end
      end
    end else begin : g_three
      logic c_n;
      assign c_n = ~c;
      maj3_gate u_lo  (.a(a), .b(b), .c(c),   .y(vote_lo));
      maj3_gate u_hi  (.a(a), .b(b), .c(c_n), .y(vote_hi));
      maj3_gate u_out (.a(vote_lo_n), .b(c), .c(vote_hi), .y(p));

      always_comb begin
        if (!$isunknown({a, b, c}))
          p_xor3_r2: assert (p == (a ^ b ^ c));
      end
    end
  endgenerate
endmodule

// File: rtl/maj_parity_tree.sv
module maj_parity_tree #(
  parameter int N  = 10,
  parameter int CW = 16
) (
  input  logic [N-1:0]  in_bits,
  output logic          parity,
  output logic [CW-1:0] maj_gates,
  output logic [CW-1:0] inv_gates,
  output logic [CW-1:0] gate_levels
);
  function automatic int width_at(int lvl);
    int w = N;
    for (int k = 0; k < lvl; k++) w = (w + 2) / 3;
    return w;
  endfunction

  function automatic int tree_depth();
    int w = N;
    int d = 0;
    while (w > 1) begin
      w = (w + 2) / 3;
      d++;
    end
    return d;
  endfunction

  function automatic int offset_of(int lvl);
    int s = 0;
    for (int k = 0; k < lvl; k++) s += width_at(k);
    return s;
  endfunction

  function automatic int full_cells();
    int s = 0;
    for (int k = 0; k < tree_depth(); k++) s += width_at(k) / 3;
    return s;
  endfunction

  function automatic int pair_cells();
    int s = 0;
    for (int k = 0; k < tree_depth(); k++) s += ((width_at(k) % 3) == 2) ? 1 : 0;
    return s;
  endfunction

  localparam int LEVELS = tree_depth();
  localparam int TOTAL  = offset_of(LEVELS) + 1;
  localparam int NC3    = full_cells();
  localparam int NC2    = pair_cells();

  logic [TOTAL-1:0] nodes;

  assign nodes[N-1:0] = in_bits;
  assign parity       = nodes[TOTAL-1];
  assign maj_gates    = CW'(3 * (NC3 + NC2));
  assign inv_gates    = CW'(2 * NC3 + NC2);
  assign gate_levels  = CW'(2 * LEVELS);

  generate
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int WI = width_at(l);
      localparam int WO = (WI + 2) / 3;
      localparam int BI = offset_of(l);
      localparam int BO = offset_of(l + 1);
      for (genvar j = 0; j < WO; j++) begin : g_grp
        localparam int G = (WI - 3 * j >= 3) ? 3 : (WI - 3 * j);
        if (G == 3) begin : g_full
          maj_xor_cell #(.TWO_IN(1'b0)) u_cell (
            .a(nodes[BI + 3*j]), .b(nodes[BI + 3*j + 1]), .c(nodes[BI + 3*j + 2]),
            .p(nodes[BO + j]));
        end else if (G == 2) begin : g_pair
          maj_xor_cell #(.TWO_IN(1'b1)) u_cell (
            .a(nodes[BI + 3*j]), .b(nodes[BI + 3*j + 1]), .c(1'b0),
            .p(nodes[BO + j]));
        end else begin : g_pass
          assign nodes[BO + j] = nodes[BI + 3*j];
        end
      end
    end
  endgenerate

  always_comb begin
    if (!$isunknown(in_bits))
      p_parity_match_r1: assert (parity == ^in_bits);
  end
endmodule

// File: tb/maj_parity_tree_tb_top.sv
module maj_parity_tree_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int cycles = 0;

  logic [0:0]  in1;
  logic [1:0]  in2;
  logic [2:0]  in3;
  logic [3:0]  in4;
  logic [8:0]  in9;
  logic [9:0]  in10;
  logic [39:0] in40;
  logic p1, p2, p3, p4, p9, p10, p40;
  logic [15:0] m1, m2, m3, m4, m9, m10, m40;
  logic [15:0] v1, v2, v3, v4, v9, v10, v40;
  logic [15:0] d1, d2, d3, d4, d9, d10, d40;

  maj_parity_tree #(.N(1))  dut_n1 (.in_bits(in1),  .parity(p1),  .maj_gates(m1),  .inv_gates(v1),  .gate_levels(d1));
  maj_parity_tree #(.N(2))  dut_n2 (.in_bits(in2),  .parity(p2),  .maj_gates(m2),  .inv_gates(v2),  .gate_levels(d2));
  maj_parity_tree #(.N(3))  dut_n3 (.in_bits(in3),  .parity(p3),  .maj_gates(m3),  .inv_gates(v3),  .gate_levels(d3));
  maj_parity_tree #(.N(4))  dut_n4 (.in_bits(in4),  .parity(p4),  .maj_gates(m4),  .inv_gates(v4),  .gate_levels(d4));
  maj_parity_tree #(.N(9))  dut_n9 (.in_bits(in9),  .parity(p9),  .maj_gates(m9),  .inv_gates(v9),  .gate_levels(d9));
  maj_parity_tree #(.N(10)) dut_i  (.in_bits(in10), .parity(p10), .maj_gates(m10), .inv_gates(v10), .gate_levels(d10));
  maj_parity_tree #(.N(40)) dut_n40(.in_bits(in40), .parity(p40), .maj_gates(m40), .inv_gates(v40), .gate_levels(d40));

  function automatic bit ref_parity(logic [39:0] w, int n);
    bit r = 1'b0;
    for (int k = 0; k < n; k++) if (w[k]) r = ~r;
    return r;
  endfunction

  task automatic chk(int got, int exp, string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic drive_all(logic [39:0] w);
    in1 = w[0:0]; in2 = w[1:0]; in3 = w[2:0]; in4 = w[3:0];
    in9 = w[8:0]; in10 = w[9:0]; in40 = w;
  endtask

  task automatic check_small(logic [39:0] w);
    chk(int'(p1),  int'(w[0]), "R8 N=1 follows input");
    chk(int'(p2),  int'(ref_parity(w, 2)),  "R3 N=2 pair cell");
    chk(int'(p3),  int'(ref_parity(w, 3)),  "R2 N=3 full cell");
    chk(int'(p4),  int'(ref_parity(w, 4)),  "R4 N=4 leftover pass");
    chk(int'(p9),  int'(ref_parity(w, 9)),  "R1 N=9 parity");
    chk(int'(p10), int'(ref_parity(w, 10)), "R1 N=10 parity");
  endtask

  initial begin
    drive_all('0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(int'(p10), 0, "R1 zero input");
    chk(int'(p40), 0, "R1 zero input N=40");
    chk(int'(m1), 0,  "R5 N=1");  chk(int'(m2), 3,  "R5 N=2");
    chk(int'(m3), 3,  "R5 N=3");  chk(int'(m4), 6,  "R5 N=4");
    chk(int'(m9), 12, "R5 N=9");  chk(int'(m10), 15, "R5 N=10");
    chk(int'(m40), 63, "R5 N=40");
    chk(int'(v1), 0,  "R6 N=1");  chk(int'(v2), 1,  "R6 N=2");
    chk(int'(v3), 2,  "R6 N=3");  chk(int'(v4), 3,  "R6 N=4");
    chk(int'(v9), 8,  "R6 N=9");  chk(int'(v10), 9,  "R6 N=10");
    chk(int'(v40), 39, "R6 N=40");
    chk(int'(d1), 0, "R7 N=1");   chk(int'(d2), 2, "R7 N=2");
    chk(int'(d3), 2, "R7 N=3");   chk(int'(d4), 4, "R7 N=4");
    chk(int'(d9), 4, "R7 N=9");   chk(int'(d10), 6, "R7 N=10");
    chk(int'(d40), 8, "R7 N=40");
    rst_n = 1'b1;

    for (int pat = 0; pat < 1024; pat++) begin
      @(posedge clk);
      drive_all(40'(pat));
      @(negedge clk);
      check_small(40'(pat));
    end

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 2000; i++) begin
      logic [39:0] w;
      w = {$urandom, $urandom};
      if (i % 3 == 0) w = w & {$urandom, $urandom} & {$urandom, $urandom};
      else if (i % 3 == 1) w = w | {$urandom, $urandom};
      @(posedge clk);
      drive_all(w);
      @(negedge clk);
      chk(int'(p40), int'(ref_parity(w, 40)), "R1 N=40 random");
      check_small(w);
    end

    @(posedge clk); drive_all({40{1'b1}});
    @(negedge clk); chk(int'(p40), 0, "R1 N=40 all ones");
    @(posedge clk); drive_all(40'h80_0000_0000);
    @(negedge clk); chk(int'(p40), 1, "R4 N=40 top leftover bit");
    @(posedge clk); drive_all(40'h00_0000_0200);
    @(negedge clk); chk(int'(p10), 1, "R4 N=10 leftover bit 9");
    summary();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      summary();
    end
  end
endmodule